// File: doc/BRIEF.md
# Clock Monitor and Watchdog Reset Controller

This block raises a reset request when either the monitored system clock stalls or software stops servicing a watchdog. It runs on a free-running controller clock. The monitored system clock enters as a data signal. Two single-cycle enable pulses drive the two detectors: one reference tick for the missing-clock detector, and one E-clock tick for the watchdog prescaler.

A small register port selects one of three addresses. The control register holds the monitor enable, a sticky force bit and the watchdog rate. The configuration address reads the working configuration latch, but writes to it are passed to an external non-volatile byte. That byte is copied into the latch only while reset is held, and the latch alone governs operation. The service address takes a two-byte key sequence that restarts the watchdog.

Each detected failure produces a registered request with a cause flag.

Top module: `clk_wdog_rst_ctrl`

## Requirements
- R1: While reset is held and just after it, `rst_req_o` is 0 and the control register reads 0x00 (monitor enable, force bit and rate all cleared).
- R2: The control register at address 0 can be written and read at any time: bit 0 is the monitor enable, bit 1 the force bit, bits 3:2 the rate code, and the other bits read 0.
- R3: Writing 1 to control bit 1 sets the force bit. No write can clear it; only reset clears it.
- R4: The monitor is active when the force bit or the enable bit is 1. When neither is set, a stopped system clock causes no request.
- R5: The system clock passes through a two-stage synchronizer. While the monitor is active, every reference tick with no synchronized clock edge advances a count, and any edge clears it. The tick that brings the count to `CM_THRESH` issues a request with `rst_cause_o`=1 and clears the count.
- R6: The watchdog issues a request with `rst_cause_o`=0 after 2^`PRESCALE_W` × D × `WD_TIMEOUT` E-clock ticks since its last restart or timeout. D is 1, 4, 16 or 64 for rate codes 00, 01, 10 and 11. Counting then begins again.
- R7: Address 1 reads the configuration latch. The latch takes the value of `nv_cfg_i` while reset is held and keeps it until the next reset. A write to address 1 raises `nv_we_o` with `nv_wdata_o` equal to the written byte and leaves the latch unchanged.
- R8: When configuration latch bit 2 is 1, the watchdog never times out.
- R9: Requests are registered and appear one cycle after the detecting tick. `rst_cause_o` is 1 only together with `rst_req_o`. When both detectors fire in the same cycle, a single request is issued with cause 1.
- R10: Writing 0x55 and then 0xAA to address 2 restarts the watchdog. Any other byte written between or before them cancels the sequence, and 0xAA without a preceding 0x55 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sys_clk_i | input | 1 | Monitored system clock, sampled as data |
| ref_tick_i | input | 1 | Reference tick for the missing-clock detector |
| e_tick_i | input | 1 | E-clock tick feeding the watchdog prescaler |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 configuration, 2 service |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for `addr_i` (combinational) |
| nv_cfg_i | input | 8 | Stored configuration byte |
| nv_we_o | output | 1 | Write strobe toward the stored byte |
| nv_wdata_o | output | 8 | Data toward the stored byte |
| rst_req_o | output | 1 | Reset request pulse |
| rst_cause_o | output | 1 | 1 = clock failure, 0 = watchdog timeout |

## Verification
The detectors have no visible state except through `rst_req_o` and `rst_cause_o`, so the bench compares those two outputs against a tick-counting model on every cycle. A miscounted watchdog stage, a wrong rate mask or a missed service restart therefore appears as a pulse that comes early, comes late or never comes, at the first timeout boundary after the fault. A monitor count that fails to clear on a clock edge appears within `CM_THRESH` reference ticks as a false cause-1 request. A configuration latch that follows writes instead of reset shows up at once on a read of address 1, and as a watchdog that is still running after the disable bit was loaded.

// File: rtl/cwr_pkg.sv
package cwr_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_CFG  = 2'd1,
    A_SVC  = 2'd2,
    A_NONE = 2'd3
  } addr_e;

  localparam logic [7:0] SVC_KEY1 = 8'h55;
  localparam logic [7:0] SVC_KEY2 = 8'hAA;
  localparam int CFG_WD_OFF_BIT   = 2;
  localparam int RATE_CNT_W       = 6;

  // divide-by 1/4/16/64 expressed as low-bit mask on a free-running count
  function automatic logic [RATE_CNT_W-1:0] rate_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    rate_mask = 6'd0;
      2'd1:    rate_mask = 6'd3;
      2'd2:    rate_mask = 6'd15;
      default: rate_mask = 6'd63;
    endcase
  endfunction
endpackage

// File: rtl/cwr_clk_mon.sv
module cwr_clk_mon #(
  parameter int THRESH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sys_clk_i,
  input  logic ref_tick_i,
  output logic fail_o
);
  localparam int CW = $clog2(THRESH + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(THRESH - 1);

  logic [2:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          clk_edge;

  assign clk_edge = sync_q[2] ^ sync_q[1];
  assign fail_o   = en_i & ~clk_edge & ref_tick_i & (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], sys_clk_i};
      if (!en_i || clk_edge)
        cnt_q <= '0;
      else if (ref_tick_i)
        cnt_q <= fail_o ? '0 : cnt_q + 1'b1;
    end
  end

  p_cm_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
  p_cm_edge_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && clk_edge) |=> (cnt_q == '0));
  p_cm_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> (cnt_q == '0));
endmodule

// File: rtl/cwr_wdog_core.sv
module cwr_wdog_core
  import cwr_pkg::*;
#(
  parameter int PRE_W   = 15,
  parameter int TIMEOUT = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dis_i,
  input  logic       restart_i,
  input  logic       e_tick_i,
  input  logic [1:0] rate_i,
  output logic       fire_o
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] TO_LAST = TW'(TIMEOUT - 1);

  logic [PRE_W-1:0]      pre_q;
  logic [RATE_CNT_W-1:0] div_q;
  logic [TW-1:0]         to_q;
  logic [RATE_CNT_W-1:0] mask;
  logic                  pre_tick, scaled;

  assign mask     = rate_mask(rate_i);
  assign pre_tick = e_tick_i & (&pre_q);
  assign scaled   = pre_tick & ((div_q & mask) == mask);
  assign fire_o   = scaled & (to_q == TO_LAST) & ~dis_i & ~restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      div_q <= '0;
      to_q  <= '0;
    end else if (dis_i || restart_i) begin
      pre_q <= '0;
      div_q <= '0;
      to_q  <= '0;
    end else begin
      if (e_tick_i) pre_q <= pre_q + 1'b1;
      if (pre_tick) div_q <= div_q + 1'b1;
      if (scaled)   to_q  <= (to_q == TO_LAST) ? '0 : to_q + 1'b1;
    end
  end

  p_wd_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |=> (to_q == '0 && pre_q == '0));
  p_wd_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (pre_q == '0 && div_q == '0 && to_q == '0));
  p_wd_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (to_q == '0 && pre_q == '0));
endmodule

// File: rtl/cwr_wdog_svc.sv
module cwr_wdog_svc
  import cwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] data_i,
  output logic       restart_o
);
  logic armed_q;

  assign restart_o = we_i & armed_q & (data_i == SVC_KEY2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   armed_q <= 1'b0;
    else if (we_i) armed_q <= (data_i == SVC_KEY1);
  end

  p_svc_disarm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !armed_q);
  p_svc_cancel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && data_i != SVC_KEY1) |=> !armed_q);
endmodule

// File: rtl/clk_wdog_rst_ctrl.sv
module clk_wdog_rst_ctrl
  import cwr_pkg::*;
#(
  parameter int PRESCALE_W = 15,
  parameter int WD_TIMEOUT = 8,
  parameter int CM_THRESH  = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sys_clk_i,
  input  logic       ref_tick_i,
  input  logic       e_tick_i,
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  input  logic [7:0] nv_cfg_i,
  output logic       nv_we_o,
  output logic [7:0] nv_wdata_o,
  output logic       rst_req_o,
  output logic       rst_cause_o
);
  addr_e      addr;
  logic       wr_ctrl, wr_cfg, wr_svc;
  logic       en_q, frc_q;
  logic [1:0] rate_q;
  logic [7:0] cfg_q;
  logic       cm_fail, wd_fire, svc_restart;
  logic       req_q, cause_q;

  assign addr    = addr_e'(addr_i);
  assign wr_ctrl = wr_en_i && addr == A_CTRL;
  assign wr_cfg  = wr_en_i && addr == A_CFG;
  assign wr_svc  = wr_en_i && addr == A_SVC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      frc_q  <= 1'b0;
      rate_q <= 2'd0;
    end else if (wr_ctrl) begin
      en_q   <= wr_data_i[0];
      frc_q  <= frc_q | wr_data_i[1];
      rate_q <= wr_data_i[3:2];
    end
  end

  // working latch: follows the stored byte only while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= nv_cfg_i;
  end

  assign nv_we_o    = wr_cfg;
  assign nv_wdata_o = wr_data_i;

  always_comb begin
    case (addr)
      A_CTRL:  rd_data_o = {4'b0, rate_q, frc_q, en_q};
      A_CFG:   rd_data_o = cfg_q;
      default: rd_data_o = 8'h00;
    endcase
  end

  cwr_clk_mon #(.THRESH(CM_THRESH)) u_clk_mon (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_q | frc_q),
    .sys_clk_i  (sys_clk_i),
    .ref_tick_i (ref_tick_i),
    .fail_o     (cm_fail)
  );

  cwr_wdog_svc u_svc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_svc),
    .data_i    (wr_data_i),
    .restart_o (svc_restart)
  );

  cwr_wdog_core #(.PRE_W(PRESCALE_W), .TIMEOUT(WD_TIMEOUT)) u_wdog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dis_i     (cfg_q[CFG_WD_OFF_BIT]),
    .restart_i (svc_restart),
    .e_tick_i  (e_tick_i),
    .rate_i    (rate_q),
    .fire_o    (wd_fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      req_q   <= cm_fail | wd_fire;
      cause_q <= cm_fail;
    end
  end

  assign rst_req_o   = req_q;
  assign rst_cause_o = cause_q;

  p_cause_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_cause_o |-> rst_req_o);
  p_cm_prio_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cm_fail && wd_fire) |=> (rst_req_o && rst_cause_o));
  p_force_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frc_q |=> frc_q);
  p_cfg_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cfg |=> $stable(cfg_q));
  p_req_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cm_fail || wd_fire) |=> !rst_req_o);
endmodule

// File: tb/clk_wdog_rst_ctrl_tb_top.sv
module clk_wdog_rst_ctrl_tb_top;
  localparam int P  = 3;
  localparam int TO = 4;
  localparam int TH = 3;

  logic       clk_i = 0, rst_ni = 0;
  logic       sys_clk_i = 0, ref_tick_i = 0, e_tick_i = 0;
  logic       wr_en_i = 0;
  logic [1:0] addr_i = 0;
  logic [7:0] wr_data_i = 0;
  logic [7:0] rd_data_o, nv_wdata_o;
  logic       nv_we_o, rst_req_o, rst_cause_o;
  logic [7:0] nv_byte = 8'h00;

  int n_chk = 0, n_fail = 0;
  int cm_n = 0, wd_n = 0;
  bit clk_run = 1, e_en = 0, done = 0;
  int tick_div = 0;

  always #5 clk_i = ~clk_i;

  clk_wdog_rst_ctrl #(.PRESCALE_W(P), .WD_TIMEOUT(TO), .CM_THRESH(TH)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sys_clk_i(sys_clk_i), .ref_tick_i(ref_tick_i),
    .e_tick_i(e_tick_i), .wr_en_i(wr_en_i), .addr_i(addr_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .nv_cfg_i(nv_byte), .nv_we_o(nv_we_o),
    .nv_wdata_o(nv_wdata_o), .rst_req_o(rst_req_o), .rst_cause_o(rst_cause_o));

  // stored byte model
  always @(posedge clk_i) if (nv_we_o) nv_byte <= nv_wdata_o;

  // free-running stimulus
  always @(negedge clk_i) begin
    tick_div   <= (tick_div + 1) % 4;
    ref_tick_i <= (tick_div == 0);
    if (clk_run) sys_clk_i <= ~sys_clk_i;
    e_tick_i <= e_en;
  end

  // behavioural reference
  bit       m_en, m_frc, m_armed, exp_req, exp_cause;
  bit [1:0] m_rate;
  bit [7:0] m_cfg;
  int       m_wd, m_cm;
  bit       hist[$];

  function automatic int wd_limit(input bit [1:0] r);
    return (1 << P) * (1 << (2 * r)) * TO;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en = 0; m_frc = 0; m_rate = 0; m_armed = 0; m_cfg = nv_byte;
      m_wd = 0; m_cm = 0; exp_req = 0; exp_cause = 0;
      hist = '{0, 0, 0};
    end else begin
      bit seen_edge, cmf, wdf, restart;
      seen_edge = (hist[1] != hist[2]);
      cmf = 0; wdf = 0;
      if (!(m_en || m_frc) || seen_edge) m_cm = 0;
      else if (ref_tick_i) begin
        m_cm++;
        if (m_cm == TH) begin cmf = 1; m_cm = 0; end
      end
      restart = wr_en_i && addr_i == 2 && wr_data_i == 8'hAA && m_armed;
      if (m_cfg[2] || restart) m_wd = 0;
      else if (e_tick_i) begin
        m_wd++;
        if (m_wd == wd_limit(m_rate)) begin wdf = 1; m_wd = 0; end
      end
      if (wr_en_i && addr_i == 2) m_armed = (wr_data_i == 8'h55);
      if (wr_en_i && addr_i == 0) begin
        m_en = wr_data_i[0]; m_frc = m_frc | wr_data_i[1]; m_rate = wr_data_i[3:2];
      end
      exp_req = cmf | wdf;
      exp_cause = cmf;
      hist.push_front(sys_clk_i);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison (R5 R6 R9)
  always @(negedge clk_i) if (rst_ni && !done) begin
    chk(rst_req_o == exp_req, "R9 R5 R6 rst_req_o vs model", rst_req_o, exp_req);
    chk(rst_cause_o == exp_cause, "R9 rst_cause_o vs model", rst_cause_o, exp_cause);
    if (rst_req_o) begin
      if (rst_cause_o) cm_n++; else wd_n++;
    end
  end

  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1; addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 0; addr_i = 0; wr_data_i = 0;
  endtask

  task automatic rd(input bit [1:0] a, input bit [7:0] exp, input string tag);
    @(negedge clk_i);
    addr_i = a;
    #1 chk(rd_data_o == exp, tag, rd_data_o, exp);
    addr_i = 0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wd_window(input bit [1:0] r, input int n, input int exp, input string tag);
    e_en = 0; idle(2);
    wr(0, {4'b0, r, 2'b00});
    wr(2, 8'h55); wr(2, 8'hAA);
    idle(2);
    wd_n = 0; cm_n = 0;
    e_en = 1; idle(n); e_en = 0; idle(4);
    chk(wd_n == exp, tag, wd_n, exp);
  endtask

  task automatic cm_window(input bit [7:0] ctrl, input bit run, input int n,
                           input int lo, input int hi, input string tag);
    e_en = 0;
    wr(0, ctrl);
    idle(2);
    cm_n = 0;
    clk_run = run; idle(n); clk_run = 1; idle(8);
    chk(cm_n >= lo && cm_n <= hi, tag, cm_n, lo);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk(rst_req_o == 0, "R1 no request after reset", rst_req_o, 0);
    rd(0, 8'h00, "R1 control clear after reset");
    rd(1, 8'h00, "R7 latch holds stored byte");
    rd(3, 8'h00, "R2 unused address reads 0");
    wr(0, 8'h09); rd(0, 8'h09, "R2 control readback");
    wr(0, 8'hF4); rd(0, 8'h04, "R2 upper control bits read 0");
    wr(0, 8'h00); rd(0, 8'h00, "R2 control cleared");

    // R6 rate windows
    wd_window(2'd0, 32 * 3 + 16, 3, "R6 rate 00 timeouts");
    wd_window(2'd1, 128 * 2 + 64, 2, "R6 rate 01 timeouts");
    wd_window(2'd3, 2048 + 1024, 1, "R6 rate 11 timeouts");

    // R10 service sequences
    wd_window(2'd0, 4, 0, "R10 restart via 55 AA");
    e_en = 1; wd_n = 0;
    for (int i = 0; i < 10; i++) begin wr(2, 8'h55); wr(2, 8'hAA); idle(20); end
    e_en = 0; idle(4);
    chk(wd_n == 0, "R10 serviced watchdog stays quiet", wd_n, 0);
    wd_window(2'd0, 0, 0, "R10 restart before bad sequence");
    e_en = 1; wd_n = 0;
    for (int i = 0; i < 6; i++) begin wr(2, 8'h55); wr(2, 8'h12); wr(2, 8'hAA); idle(26); end
    e_en = 0; idle(4);
    chk(wd_n == 6, "R10 broken sequence does not restart", wd_n, 6);
    wd_window(2'd0, 0, 0, "R10 restart before lone AA");
    e_en = 1; wd_n = 0;
    for (int i = 0; i < 4; i++) begin wr(2, 8'hAA); idle(30); end
    e_en = 0; idle(4);
    chk(wd_n == 4, "R10 lone AA does not restart", wd_n, 4);

    // clock monitor
    cm_window(8'h00, 0, 120, 0, 0, "R4 disabled monitor ignores stopped clock");
    cm_window(8'h01, 1, 120, 0, 0, "R5 running clock raises nothing");
    cm_window(8'h01, 0, 120, 8, 10, "R5 stopped clock raises cause 1");
    wr(0, 8'h02); rd(0, 8'h02, "R3 force bit set");
    wr(0, 8'h00); rd(0, 8'h02, "R3 force bit survives write of 0");
    cm_window(8'h00, 0, 120, 8, 10, "R4 force overrides cleared enable");

    // configuration latch
    @(negedge clk_i);
    wr_en_i = 1; addr_i = 1; wr_data_i = 8'h04;
    #1 chk(nv_we_o == 1 && nv_wdata_o == 8'h04, "R7 write forwarded to stored byte", nv_wdata_o, 8'h04);
    @(negedge clk_i);
    wr_en_i = 0; addr_i = 0; wr_data_i = 0;
    rd(1, 8'h00, "R7 latch unchanged by write");
    do_reset();
    rd(0, 8'h00, "R1 force cleared by reset");
    rd(1, 8'h04, "R7 latch reloaded during reset");
    wd_window(2'd0, 32 * 5, 0, "R8 disabled watchdog never fires");
    wr(1, 8'h00);
    do_reset();
    rd(1, 8'h00, "R7 latch reloaded with 0");
    wd_window(2'd0, 32 + 8, 1, "R8 enabled watchdog fires again");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule